// File: doc/BRIEF.md
# Debug Control Register with Breakpoint Logic

This block holds the 8-bit control register of an on-chip debugger that sits beside a small 8-bit processor core. A host reads and writes the register over a simple register bus. The register's top bit is a debug-mode flag. While the flag is set, the core is told to stop fetching instructions. The flag can be set by the host, or by hardware when the core's decoder reports the breakpoint opcode and breakpoints are enabled. When flash read protection is active, the host cannot clear the flag. Only the debugger's own reset can clear it in that case.

When a breakpoint is taken and acknowledge is enabled, the block asks the serial debug link to send one acknowledge byte to the host. It uses a valid/ready handshake for this. Writing 1 to the lowest bit asks for a system reset. That bit reads as 1 until the reset controller reports that the sequence has finished. The register itself is cleared only by the debugger reset `rst_n`, so its contents survive a system reset requested through this bit.

Two small state machines carry the sequenced behaviour:

- Acknowledge machine. It has the states ACK_IDLE and ACK_SEND. IDLE moves to SEND when an acknowledged breakpoint is taken. SEND moves back to IDLE when the link accepts the byte. If a new acknowledged breakpoint is taken in the same cycle as that acceptance, the machine stays in SEND.
- Reset machine. It has the states RST_IDLE and RST_BUSY. IDLE moves to BUSY when the host writes 1 to bit 0. BUSY moves back to IDLE on the completion pulse.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After `rst_n` is released, `bus_rdata` is 00H and `halt_fetch`, `ack_valid` and `sys_rst_req` are 0.
- R2: Register layout as seen on `bus_rdata`:
  - bit 7 is the debug-mode flag;
  - bit 6 is breakpoint enable;
  - bit 5 is acknowledge enable;
  - bits 4:1 always read 0, whatever value was written to them;
  - bit 0 is the system-reset bit.
  
  A host write (`bus_wr`=1) takes effect at the next clock edge.
- R3: `halt_fetch` is 1 in every cycle where the debug-mode flag is 1, and 0 in every cycle where the flag is 0.
- R4: When breakpoint enable is 0, a decode of opcode 00H does not change the debug-mode flag. A decode of any other opcode never sets the flag.
- R5: When breakpoint enable is 1 and `op_valid` is 1 with `op_code` = 00H, the debug-mode flag reads 1 after the next edge.
- R6: While `rdp_active` is 1, a host write with bit 7 = 0 leaves the flag unchanged. While `rdp_active` is 0, such a write clears the flag.
- R7: A breakpoint taken while acknowledge enable is 1 raises `ack_valid` after the next edge, with `ack_data` = FFH. `ack_valid` stays high until a cycle in which `ack_ready` is 1.
- R8: A breakpoint taken while acknowledge enable is 0 does not raise `ack_valid`.
- R9: A host write with bit 0 = 1 sets `sys_rst_req` and bit 0 of `bus_rdata` to 1 after the next edge. Both stay 1 until the edge at which `sys_rst_done` is 1, and are 0 after it. Bits 7:5 are not disturbed.
- R10: If a host write that would clear the flag happens in the same cycle as a taken breakpoint, the flag becomes 1.
- R11: Writing 0 to bit 0 does not start a system reset. A `sys_rst_done` pulse while no reset is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low debugger reset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Register read value |
| op_valid | input | 1 | Decoder reports an opcode this cycle |
| op_code | input | 8 | Decoded opcode |
| rdp_active | input | 1 | Flash read protection is active |
| halt_fetch | output | 1 | Stop instruction fetch |
| ack_valid | output | 1 | Acknowledge byte pending for the link |
| ack_data | output | 8 | Acknowledge byte |
| ack_ready | input | 1 | Link accepts the byte |
| sys_rst_req | output | 1 | System reset request (debugger excluded) |
| sys_rst_done | input | 1 | Pulse: reset sequence finished |

## Verification
The breakpoint path is tried with four patterns:

- opcode 00H while breakpoints are disabled, which tells a missing enable gate apart;
- a non-breakpoint opcode while breakpoints are enabled, which tells a broken opcode compare apart;
- opcode 00H with acknowledge both enabled and disabled, which separates the acknowledge gate from the flag set;
- opcode 00H in the same cycle as a clearing write, which exposes the wrong priority.

Clearing writes are issued with read protection both on and off, to separate the protection block from an ordinary clear. The reset bit is exercised with the completion pulse held back for several cycles, and with completion pulses sent while idle. A seeded random phase then mixes all inputs against a bench model.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned BIT_DBG = 7;
    localparam int unsigned BIT_BRK = 6;
    localparam int unsigned BIT_ACK = 5;
    localparam int unsigned BIT_RST = 0;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_SEND = 1'b1
    } ack_state_e;

    typedef enum logic {
        RST_IDLE = 1'b0,
        RST_BUSY = 1'b1
    } rst_state_e;
endpackage

// File: rtl/dbg_ack_fsm.sv
module dbg_ack_fsm
    import dbg_ctl_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter logic [DW-1:0] ACK_BYTE = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data
);
    ack_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (req) state_d = ACK_SEND;
            ACK_SEND: if (ready) state_d = req ? ACK_SEND : ACK_IDLE;
            default:  state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        valid = (state_q == ACK_SEND);
        data  = ACK_BYTE;
    end
endmodule

// File: rtl/dbg_rst_fsm.sv
module dbg_rst_fsm
    import dbg_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);
    rst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE: if (start) state_d = RST_BUSY;
            RST_BUSY: if (done)  state_d = RST_IDLE;
            default:  state_d = RST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_IDLE;
        else        state_q <= state_d;
    end

    always_comb busy = (state_q == RST_BUSY);
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbg_ctl_pkg::*;
#(
    parameter logic [REG_W-1:0] BRK_OPCODE = 8'h00,
    parameter logic [REG_W-1:0] ACK_BYTE   = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             op_valid,
    input  logic [REG_W-1:0] op_code,
    input  logic             rdp_active,
    output logic             halt_fetch,
    output logic             ack_valid,
    output logic [REG_W-1:0] ack_data,
    input  logic             ack_ready,
    output logic             sys_rst_req,
    input  logic             sys_rst_done
);
    logic dbg_q, brk_en_q, ack_en_q;
    logic dbg_d, brk_en_d, ack_en_d;
    logic brk_take;
    logic rst_busy;

    // breakpoint is taken only with enable set and the exact opcode
    always_comb brk_take = op_valid && (op_code == BRK_OPCODE) && brk_en_q;

    always_comb begin
        dbg_d    = dbg_q;
        brk_en_d = brk_en_q;
        ack_en_d = ack_en_q;
        if (bus_wr) begin
            brk_en_d = bus_wdata[BIT_BRK];
            ack_en_d = bus_wdata[BIT_ACK];
            if (bus_wdata[BIT_DBG])  dbg_d = 1'b1;
            else if (!rdp_active)    dbg_d = 1'b0;
        end
        if (brk_take) dbg_d = 1'b1;   // hardware set wins over a host clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_q    <= 1'b0;
            brk_en_q <= 1'b0;
            ack_en_q <= 1'b0;
        end else begin
            dbg_q    <= dbg_d;
            brk_en_q <= brk_en_d;
            ack_en_q <= ack_en_d;
        end
    end

    dbg_ack_fsm #(.DW(REG_W), .ACK_BYTE(ACK_BYTE)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (brk_take && ack_en_q),
        .ready (ack_ready),
        .valid (ack_valid),
        .data  (ack_data)
    );

    dbg_rst_fsm u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bus_wr && bus_wdata[BIT_RST]),
        .done  (sys_rst_done),
        .busy  (rst_busy)
    );

    always_comb begin
        bus_rdata          = '0;
        bus_rdata[BIT_DBG] = dbg_q;
        bus_rdata[BIT_BRK] = brk_en_q;
        bus_rdata[BIT_ACK] = ack_en_q;
        bus_rdata[BIT_RST] = rst_busy;
        halt_fetch         = dbg_q;
        sys_rst_req        = rst_busy;
    end
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic       rdp_active,
    input logic       ack_valid,
    input logic [7:0] ack_data,
    input logic       ack_ready,
    input logic       sys_rst_req,
    input logic       sys_rst_done
);
    logic take;
    assign take = op_valid && (op_code == 8'h00) && bus_rdata[6];

    a_r5_brk_sets: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> bus_rdata[7]);

    a_r4_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !take) |=> $stable(bus_rdata[7]));

    a_r6_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdp_active && bus_rdata[7]) |=> bus_rdata[7]);

    a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_ready) |=> (ack_valid && ack_data == 8'hFF));

    a_r8_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid && !(take && bus_rdata[5])) |=> !ack_valid);

    a_r9_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !sys_rst_done) |=> sys_rst_req);

    a_r11_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_req && !(bus_wr && $past(1'b1) && 1'b0) && !bus_wr) |=> !sys_rst_req);
endmodule

bind dbg_ctl_reg dbg_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .rdp_active   (rdp_active),
    .ack_valid    (ack_valid),
    .ack_data     (ack_data),
    .ack_ready    (ack_ready),
    .sys_rst_req  (sys_rst_req),
    .sys_rst_done (sys_rst_done)
);

// File: tb/dbg_ctl_reg_tb.sv
module dbg_ctl_reg_tb;
    localparam time CLK_P = 5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h55;
    logic       rdp_active = 1'b0;
    logic       halt_fetch;
    logic       ack_valid;
    logic [7:0] ack_data;
    logic       ack_ready = 1'b0;
    logic       sys_rst_req;
    logic       sys_rst_done = 1'b0;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic m_dbg = 0, m_brk = 0, m_acken = 0, m_busy = 0, m_av = 0;

    always #(CLK_P/2) clk = ~clk;

    dbg_ctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .op_valid(op_valid), .op_code(op_code),
        .rdp_active(rdp_active), .halt_fetch(halt_fetch), .ack_valid(ack_valid),
        .ack_data(ack_data), .ack_ready(ack_ready), .sys_rst_req(sys_rst_req),
        .sys_rst_done(sys_rst_done)
    );

    function automatic logic [7:0] exp_rdata();
        return {m_dbg, m_brk, m_acken, 4'b0000, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk(tag, {bus_rdata, halt_fetch, ack_valid, sys_rst_req},
                 {exp_rdata(), m_dbg, m_av, m_busy});
        if (ack_valid) chk(tag, ack_data, 8'hFF);
    endtask

    // drive at negedge, model the edge, compare just after the edge
    task automatic step(input logic wr, input logic [7:0] wd, input logic ov,
                        input logic [7:0] oc, input logic rdp, input logic rdy,
                        input logic done, input string tag);
        logic take, n_dbg;
        @(negedge clk);
        bus_wr = wr; bus_wdata = wd; op_valid = ov; op_code = oc;
        rdp_active = rdp; ack_ready = rdy; sys_rst_done = done;
        @(posedge clk);
        take  = ov && (oc == 8'h00) && m_brk;
        n_dbg = m_dbg;
        if (wr) n_dbg = wd[7] ? 1'b1 : (rdp ? m_dbg : 1'b0);
        if (take) n_dbg = 1'b1;
        if (!m_av) m_av = take && m_acken;
        else if (rdy) m_av = take && m_acken;
        if (!m_busy) m_busy = wr && wd[0];
        else if (done) m_busy = 1'b0;
        if (wr) begin m_brk = wd[6]; m_acken = wd[5]; end
        m_dbg = n_dbg;
        #1;
        cmp_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 8'h55, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        cmp_all("R1 reset state");
        chk("R1 outputs", {halt_fetch, ack_valid, sys_rst_req}, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        idle("R1 after release");

        // R2: reserved bits read 0, field positions
        step(1, 8'hFE, 0, 8'h55, 0, 0, 0, "R2 write FE");
        chk("R2 layout", bus_rdata, 8'hE0);
        chk("R3 halt high", halt_fetch, 1'b1);
        step(1, 8'h00, 0, 8'h55, 0, 0, 0, "R6 clear unprotected");
        chk("R3 halt low", halt_fetch, 1'b0);

        // R4: opcode 00 with breakpoints disabled
        step(0, 8'h00, 1, 8'h00, 0, 0, 0, "R4 brk disabled");
        chk("R4 flag stays", bus_rdata[7], 1'b0);
        step(1, 8'h40, 0, 8'h55, 0, 0, 0, "R2 enable brk");
        step(0, 8'h00, 1, 8'h12, 0, 0, 0, "R4 other opcode");
        chk("R4 other opcode", bus_rdata[7], 1'b0);
        step(0, 8'h00, 1, 8'h00, 0, 0, 0, "R5 brk taken");
        chk("R5 flag set", bus_rdata[7], 1'b1);
        chk("R8 no ack", ack_valid, 1'b0);

        // R6: protected clear ignored
        step(1, 8'h60, 0, 8'h55, 1, 0, 0, "R6 protected clear");
        chk("R6 flag kept", bus_rdata, 8'hE0);
        step(1, 8'h60, 0, 8'h55, 0, 0, 0, "R6 unprotected clear");
        chk("R6 flag cleared", bus_rdata, 8'h60);

        // R7: acknowledge handshake
        step(0, 8'h00, 1, 8'h00, 0, 0, 0, "R7 brk with ack");
        chk("R7 ack valid", {ack_valid, ack_data}, 9'h1FF);
        idle("R7 hold 1");
        idle("R7 hold 2");
        chk("R7 still valid", ack_valid, 1'b1);
        step(0, 8'h00, 0, 8'h55, 0, 1, 0, "R7 accept");
        chk("R7 released", ack_valid, 1'b0);

        // R10: clearing write and breakpoint in one cycle
        step(1, 8'h40, 0, 8'h55, 0, 0, 0, "R10 prep clear");
        step(1, 8'h40, 1, 8'h00, 0, 0, 0, "R10 collide");
        chk("R10 hw set wins", bus_rdata[7], 1'b1);

        // R9: system reset request
        step(1, 8'hE1, 0, 8'h55, 0, 0, 0, "R9 start");
        chk("R9 req", {sys_rst_req, bus_rdata}, {1'b1, 8'hE1});
        repeat (3) idle("R9 waiting");
        chk("R9 held", sys_rst_req, 1'b1);
        step(0, 8'h00, 0, 8'h55, 0, 0, 1, "R9 done");
        chk("R9 cleared", {sys_rst_req, bus_rdata}, {1'b0, 8'hE0});

        // R11: no spurious reset
        step(1, 8'hE0, 0, 8'h55, 0, 0, 0, "R11 write bit0 zero");
        chk("R11 no req", sys_rst_req, 1'b0);
        step(0, 8'h00, 0, 8'h55, 0, 0, 1, "R11 stray done");
        chk("R11 idle stable", {sys_rst_req, bus_rdata}, {1'b0, 8'hE0});
        step(1, 8'h00, 0, 8'h55, 0, 0, 0, "R6 final clear");

        // seeded random phase checked against the model (R3 R5 R6 R7 R9)
        for (int i = 0; i < 3000; i++) begin
            logic       wr, ov, rdp, rdy, dn;
            logic [7:0] wd, oc;
            wr  = ($urandom % 4) == 0;
            wd  = $urandom;
            if (($urandom % 4) != 0) wd[0] = 1'b0;
            ov  = $urandom % 2;
            oc  = ($urandom % 2) ? 8'h00 : 8'($urandom);
            rdp = $urandom % 2;
            rdy = $urandom % 2;
            dn  = ($urandom % 6) == 0;
            step(wr, wd, ov, oc, rdp, rdy, dn, "RAND R3 R5 R6 R7 R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule